// File: doc/BRIEF.md
# Condition Flag and Predication Unit

This block keeps the four arithmetic status flags of a processor core (negative, zero, carry, overflow) and decides, for every instruction that reaches it, whether that instruction is allowed to take effect. Each instruction brings a 4-bit condition field. The unit tests it against the flags as they stand before the instruction. If the test fails, the instruction is turned into a no-op: it writes no register and changes no flag.

An instruction that executes may update the flags. For ordinary arithmetic and logical classes this happens only when the instruction's set-flags bit is 1. The four compare classes always update the flags and never write a destination register. They are subtract-compare, add-compare, AND-test and XOR-test. The unit computes the compare results itself from the two operands. Ordinary classes take their flags from the result, carry and overflow that the external ALU supplies.

A flag update is written into the status register at the clock edge, so the next instruction sees it.

Top module: `flagpred_unit`

## Requirements
- R1: While reset is asserted and after reset is released, `flags` reads 4'b0000. With `instValid` low, `execEn` and `regWrEn` are 0. The bit layout of `flags` is {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R2: Class 0 (arithmetic) with `setFlags` = 1 loads N = `aluResult` MSB, Z = (`aluResult` == 0), C = `aluCarry` and V = `aluOverflow`. With `setFlags` = 0 the flags are unchanged.
- R3: Class 1 (logical) with `setFlags` = 1 loads N, Z and C the same way as class 0 and keeps V. With `setFlags` = 0 the flags are unchanged.
- R4: Class 2 (subtract-compare) always loads N and Z from `opA - opB`. C is 1 when no borrow occurs, that is when `opA >= opB` unsigned. V is the signed overflow of the subtraction.
- R5: Class 3 (add-compare) always loads N and Z from `opA + opB`. C is the carry out of the MSB and V is the signed overflow of the addition.
- R6: Class 4 (AND-test) always loads N and Z from `opA & opB` and C from `aluCarry`. V keeps its prior value.
- R7: Class 5 (XOR-test) always loads N and Z from `opA ^ opB` and C from `aluCarry`. V keeps its prior value.
- R8: Classes 6 and 7 (plain operations) never change the flags, whatever `setFlags` is.
- R9: The condition codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V) and 13 Z|(N!=V). With `instValid` high, `execEn` equals the code's value on the current flags.
- R10: Code 14 always executes. Code 15 never executes.
- R11: When `execEn` is 0, the instruction writes no register and changes no flag.
- R12: The condition of an instruction is evaluated on the flags before that instruction's own update. The update is visible to the next instruction.
- R13: `regWrEn` is 1 exactly when an instruction executes and its class is not 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction is presented this cycle |
| condCode | input | 4 | Condition field of the instruction |
| setFlags | input | 1 | Flag-update enable for classes 0 and 1 |
| opClass | input | 3 | Operation class, 0 to 7 |
| opA | input | DATA_W | First operand, used by compare classes |
| opB | input | DATA_W | Second operand, used by compare classes |
| aluResult | input | DATA_W | ALU result for classes 0 and 1 |
| aluCarry | input | 1 | ALU or shifter carry |
| aluOverflow | input | 1 | ALU signed overflow |
| execEn | output | 1 | Instruction executes (condition true) |
| regWrEn | output | 1 | Destination register may be written |
| flags | output | 4 | Status register {N,Z,C,V} |

## Verification
Condition evaluation and the flag update fall in the same cycle when a flag-setting instruction is itself predicated. The bench provokes this in three ways. It issues compare instructions whose condition depends on the very flags they are about to overwrite. It runs a sweep in which every condition code is presented right after a flag load. It runs long random streams that mix predicated compares with predicated readers.

The behavioural reference in the bench decides `execEn` from the old flags and commits the new flags only after the clock edge. Every cycle, `execEn`, `regWrEn` and `flags` are compared against it, and several corner values are also checked against literal results.

// File: rtl/flagpred_pkg.sv
package flagpred_pkg;

  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_LOGIC = 3'd1,
    CLS_CMPSUB = 3'd2,
    CLS_CMPADD = 3'd3,
    CLS_TSTAND = 3'd4,
    CLS_TSTXOR = 3'd5,
    CLS_PLAIN0 = 3'd6,
    CLS_PLAIN1 = 3'd7
  } opClass_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } condCode_e;

  typedef enum logic [2:0] {
    SRC_ALU = 3'd0,
    SRC_SUB = 3'd1,
    SRC_ADD = 3'd2,
    SRC_AND = 3'd3,
    SRC_XOR = 3'd4
  } flagSrc_e;

  typedef struct packed {
    logic [FLAG_W-1:0] updMask;
    flagSrc_e          src;
  } flagStrobe_t;

endpackage

// File: rtl/flagpred_cond.sv
module flagpred_cond
  import flagpred_pkg::*;
(
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [3:0]        condCode,
  output logic              condPass
);

  logic fN, fZ, fC, fV;
  logic signedGe;

  assign fN = flagsIn[FLAG_N];
  assign fZ = flagsIn[FLAG_Z];
  assign fC = flagsIn[FLAG_C];
  assign fV = flagsIn[FLAG_V];
  assign signedGe = (fN == fV);

  always_comb begin
    unique case (condCode_e'(condCode))
      CC_EQ: condPass = fZ;
      CC_NE: condPass = !fZ;
      CC_CS: condPass = fC;
      CC_CC: condPass = !fC;
      CC_MI: condPass = fN;
      CC_PL: condPass = !fN;
      CC_VS: condPass = fV;
      CC_VC: condPass = !fV;
      CC_HI: condPass = fC && !fZ;
      CC_LS: condPass = !fC || fZ;
      CC_GE: condPass = signedGe;
      CC_LT: condPass = !signedGe;
      CC_GT: condPass = !fZ && signedGe;
      CC_LE: condPass = fZ || !signedGe;
      CC_AL: condPass = 1'b1;
      CC_NV: condPass = 1'b0;
      default: condPass = 1'b0;
    endcase
  end

endmodule

// File: rtl/flagpred_ctrl.sv
module flagpred_ctrl
  import flagpred_pkg::*;
(
  input  logic              instValid,
  input  logic [3:0]        condCode,
  input  logic              setFlags,
  input  logic [2:0]        opClass,
  input  logic [FLAG_W-1:0] flagsCur,
  output logic              execEn,
  output logic              regWrEn,
  output flagStrobe_t       strobe
);

  localparam logic [FLAG_W-1:0] MASK_ALL = '1;
  localparam logic [FLAG_W-1:0] MASK_NZC = MASK_ALL & ~(FLAG_W'(1) << FLAG_V);
  localparam logic [FLAG_W-1:0] MASK_NONE = '0;

  logic     condPass;
  logic     isCompare;
  opClass_e cls;

  flagpred_cond u_cond (
    .flagsIn (flagsCur),
    .condCode(condCode),
    .condPass(condPass)
  );

  assign cls = opClass_e'(opClass);
  assign execEn = instValid && condPass;

  always_comb begin
    unique case (cls)
      CLS_CMPSUB, CLS_CMPADD, CLS_TSTAND, CLS_TSTXOR: isCompare = 1'b1;
      default:                                         isCompare = 1'b0;
    endcase
  end

  assign regWrEn = execEn && !isCompare;

  always_comb begin
    strobe.src = SRC_ALU;
    strobe.updMask = MASK_NONE;
    unique case (cls)
      CLS_ARITH: strobe.updMask = setFlags ? MASK_ALL : MASK_NONE;
      CLS_LOGIC: strobe.updMask = setFlags ? MASK_NZC : MASK_NONE;
      CLS_CMPSUB: begin
        strobe.src = SRC_SUB;
        strobe.updMask = MASK_ALL;
      end
      CLS_CMPADD: begin
        strobe.src = SRC_ADD;
        strobe.updMask = MASK_ALL;
      end
      CLS_TSTAND: begin
        strobe.src = SRC_AND;
        strobe.updMask = MASK_NZC;
      end
      CLS_TSTXOR: begin
        strobe.src = SRC_XOR;
        strobe.updMask = MASK_NZC;
      end
      default: strobe.updMask = MASK_NONE;
    endcase
    if (!execEn) strobe.updMask = MASK_NONE;
  end

endmodule

// File: rtl/flagpred_dp.sv
module flagpred_dp
  import flagpred_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  output logic [FLAG_W-1:0] flagsQ
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   subExt;
  logic [DATA_W:0]   addExt;
  logic [DATA_W-1:0] candRes;
  logic              candCarry;
  logic              candOvf;
  logic [FLAG_W-1:0] candFlags;
  logic              subOvf;
  logic              addOvf;

  // subtract as A + ~B + 1, so the carry out is the not-borrow
  assign subExt = {1'b0, opA} + {1'b0, ~opB} + {{DATA_W{1'b0}}, 1'b1};
  assign addExt = {1'b0, opA} + {1'b0, opB};

  assign subOvf = (opA[MSB] ^ opB[MSB]) & (subExt[MSB] ^ opA[MSB]);
  assign addOvf = ~(opA[MSB] ^ opB[MSB]) & (addExt[MSB] ^ opA[MSB]);

  always_comb begin
    candRes = aluResult;
    candCarry = aluCarry;
    candOvf = aluOverflow;
    unique case (strobe.src)
      SRC_SUB: begin
        candRes = subExt[MSB:0];
        candCarry = subExt[DATA_W];
        candOvf = subOvf;
      end
      SRC_ADD: begin
        candRes = addExt[MSB:0];
        candCarry = addExt[DATA_W];
        candOvf = addOvf;
      end
      SRC_AND: candRes = opA & opB;
      SRC_XOR: candRes = opA ^ opB;
      default: ;
    endcase
  end

  always_comb begin
    candFlags = '0;
    candFlags[FLAG_N] = candRes[MSB];
    candFlags[FLAG_Z] = (candRes == '0);
    candFlags[FLAG_C] = candCarry;
    candFlags[FLAG_V] = candOvf;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagsQ[i] <= 1'b0;
      end else if (strobe.updMask[i]) begin
        flagsQ[i] <= candFlags[i];
      end
    end
  end

endmodule

// File: rtl/flagpred_unit.sv
module flagpred_unit
  import flagpred_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        condCode,
  input  logic              setFlags,
  input  logic [2:0]        opClass,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  output logic              execEn,
  output logic              regWrEn,
  output logic [3:0]        flags
);

  flagStrobe_t       strobe;
  logic [FLAG_W-1:0] flagsQ;

  flagpred_ctrl u_ctrl (
    .instValid(instValid),
    .condCode (condCode),
    .setFlags (setFlags),
    .opClass  (opClass),
    .flagsCur (flagsQ),
    .execEn   (execEn),
    .regWrEn  (regWrEn),
    .strobe   (strobe)
  );

  flagpred_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .aluResult  (aluResult),
    .aluCarry   (aluCarry),
    .aluOverflow(aluOverflow),
    .flagsQ     (flagsQ)
  );

  assign flags = flagsQ;

endmodule

// File: rtl/flagpred_chk.sv
module flagpred_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [3:0]        condCode,
  input logic              setFlags,
  input logic [2:0]        opClass,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              execEn,
  input logic              regWrEn,
  input logic [3:0]        flags
);

  // R1
  idle_no_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!execEn && !regWrEn));

  // R10
  never_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condCode == 4'd15) |-> !execEn);

  // R10
  always_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condCode == 4'd14) |-> execEn);

  // R9
  eq_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && condCode == 4'd0) |-> (execEn == flags[2]));

  // R11
  annul_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> $stable(flags));

  // R13
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && opClass >= 3'd2 && opClass <= 3'd5) |-> !regWrEn);

  // R6 R7
  test_keeps_v_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && (opClass == 3'd4 || opClass == 3'd5)) |=> (flags[0] == $past(flags[0])));

  // R4
  cmp_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && opClass == 3'd2) |=> (flags[1] == ($past(opA) >= $past(opB))));

  // R2
  noset_arith_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && opClass == 3'd0 && !setFlags) |=> $stable(flags));

  // R8
  plain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opClass >= 3'd6) |=> $stable(flags));

endmodule

bind flagpred_unit flagpred_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .instValid(instValid),
  .condCode (condCode),
  .setFlags (setFlags),
  .opClass  (opClass),
  .opA      (opA),
  .opB      (opB),
  .execEn   (execEn),
  .regWrEn  (regWrEn),
  .flags    (flags)
);

// File: tb/flagpred_unit_tb.sv
`timescale 1ns/1ps
module flagpred_unit_tb;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic [3:0]    condCode = 4'd0;
  logic          setFlags = 1'b0;
  logic [2:0]    opClass = 3'd6;
  logic [DW-1:0] opA = '0, opB = '0, aluResult = '0;
  logic          aluCarry = 1'b0, aluOverflow = 1'b0;
  logic          execEn, regWrEn;
  logic [3:0]    flags;

  int checks = 0;
  int failures = 0;
  logic [3:0] refFlags = 4'b0000;

  always #5 clk = ~clk;

  flagpred_unit #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .condCode(condCode),
    .setFlags(setFlags), .opClass(opClass), .opA(opA), .opB(opB),
    .aluResult(aluResult), .aluCarry(aluCarry), .aluOverflow(aluOverflow),
    .execEn(execEn), .regWrEn(regWrEn), .flags(flags)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flags are {N,Z,C,V}
  function automatic logic refPass(input logic [3:0] f, input logic [3:0] cc);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] refNext(input logic [3:0] f, input logic [2:0] cls,
      input logic sf, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] r, input logic c, input logic v);
    logic [32:0] wide;
    logic [31:0] t;
    case (cls)
      0: return sf ? {r[31], r == 0, c, v} : f;
      1: return sf ? {r[31], r == 0, c, f[0]} : f;
      2: begin
        t = a - b;
        return {t[31], t == 0, a >= b,
                (a[31] != b[31]) && (t[31] != a[31])};
      end
      3: begin
        wide = {1'b0, a} + {1'b0, b};
        return {wide[31], wide[31:0] == 0, wide[32],
                (a[31] == b[31]) && (wide[31] != a[31])};
      end
      4: begin t = a & b; return {t[31], t == 0, c, f[0]}; end
      5: begin t = a ^ b; return {t[31], t == 0, c, f[0]}; end
      default: return f;
    endcase
  endfunction

  // one instruction: drive at negedge, compare just after, commit reference after posedge
  task automatic step(input string req, input logic [3:0] cc, input logic [2:0] cls,
      input logic sf, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] r, input logic c, input logic v);
    logic pass;
    logic [3:0] nxt;
    @(negedge clk);
    instValid = 1'b1; condCode = cc; opClass = cls; setFlags = sf;
    opA = a; opB = b; aluResult = r; aluCarry = c; aluOverflow = v;
    #1;
    pass = refPass(refFlags, cc);
    nxt = pass ? refNext(refFlags, cls, sf, a, b, r, c, v) : refFlags;
    check(req, "execEn", {31'd0, execEn}, {31'd0, pass});
    check("R13", "regWrEn", {31'd0, regWrEn}, {31'd0, pass && !(cls >= 2 && cls <= 5)});
    check("R12", "flags before update", {28'd0, flags}, {28'd0, refFlags});
    @(posedge clk);
    refFlags = nxt;
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0; opClass = 3'd6;
  endtask

  task automatic expectFlags(input string req, input logic [3:0] exp);
    @(negedge clk);
    instValid = 1'b0; opClass = 3'd6;
    #1;
    check(req, "flags", {28'd0, flags}, {28'd0, exp});
    check(req, "flags vs model", {28'd0, flags}, {28'd0, refFlags});
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "flags in reset", {28'd0, flags}, 32'd0);
    check("R1", "execEn idle", {31'd0, execEn}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1", "flags after reset", {28'd0, flags}, 32'd0);
    check("R1", "regWrEn idle", {31'd0, regWrEn}, 32'd0);

    // R4 subtract-compare corners
    step("R4", 4'd14, 3'd2, 1'b0, 32'd5, 32'd5, 32'hdead, 1'b0, 1'b1);
    expectFlags("R4", 4'b0110);
    step("R4", 4'd14, 3'd2, 1'b0, 32'd0, 32'd1, 32'h0, 1'b1, 1'b1);
    expectFlags("R4", 4'b1000);
    step("R4", 4'd14, 3'd2, 1'b0, 32'h7fffffff, 32'hffffffff, 32'h0, 1'b0, 1'b0);
    expectFlags("R4", 4'b1001);

    // R6 AND-test keeps V
    step("R6", 4'd14, 3'd4, 1'b0, 32'hf0, 32'h0f, 32'h0, 1'b1, 1'b0);
    expectFlags("R6", 4'b0111);
    // R7 XOR-test keeps V
    step("R7", 4'd14, 3'd5, 1'b0, 32'h80000000, 32'h0, 32'h0, 1'b0, 1'b0);
    expectFlags("R7", 4'b1001);

    // R11 failed condition (Z=0, code EQ) blocks a compare
    step("R11", 4'd0, 3'd2, 1'b0, 32'd7, 32'd7, 32'h0, 1'b0, 1'b0);
    expectFlags("R11", 4'b1001);
    // R10 never code blocks a flag-setting arithmetic op
    step("R10", 4'd15, 3'd0, 1'b1, 32'd0, 32'd0, 32'h0, 1'b1, 1'b0);
    expectFlags("R10", 4'b1001);

    // R5 add-compare wrapping to zero
    step("R5", 4'd14, 3'd3, 1'b0, 32'hffffffff, 32'd1, 32'h0, 1'b0, 1'b1);
    expectFlags("R5", 4'b0110);
    step("R5", 4'd14, 3'd3, 1'b0, 32'h7fffffff, 32'd1, 32'h0, 1'b0, 1'b0);
    expectFlags("R5", 4'b1001);

    // R2 arithmetic with and without set-flags
    step("R2", 4'd14, 3'd0, 1'b0, 32'd0, 32'd0, 32'h0, 1'b1, 1'b0);
    expectFlags("R2", 4'b1001);
    step("R2", 4'd14, 3'd0, 1'b1, 32'd0, 32'd0, 32'h0, 1'b1, 1'b0);
    expectFlags("R2", 4'b0110);
    // R3 logical keeps V
    step("R2", 4'd14, 3'd0, 1'b1, 32'd0, 32'd0, 32'h1, 1'b0, 1'b1);
    step("R3", 4'd14, 3'd1, 1'b1, 32'd0, 32'd0, 32'h80000000, 1'b1, 1'b0);
    expectFlags("R3", 4'b1011);
    step("R3", 4'd14, 3'd1, 1'b0, 32'd0, 32'd0, 32'h0, 1'b0, 1'b0);
    expectFlags("R3", 4'b1011);
    // R8 plain classes ignore set-flags
    step("R8", 4'd14, 3'd6, 1'b1, 32'd0, 32'd0, 32'h0, 1'b0, 1'b0);
    step("R8", 4'd14, 3'd7, 1'b1, 32'd3, 32'd3, 32'h0, 1'b0, 1'b0);
    expectFlags("R8", 4'b1011);

    // R12 back-to-back: compare sets Z, next instruction predicated on EQ
    step("R12", 4'd14, 3'd2, 1'b0, 32'd3, 32'd3, 32'h0, 1'b0, 1'b0);
    step("R12", 4'd0, 3'd0, 1'b1, 32'd0, 32'd0, 32'h1234, 1'b0, 1'b0);
    step("R12", 4'd0, 3'd2, 1'b0, 32'd9, 32'd9, 32'h0, 1'b0, 1'b0);
    expectFlags("R12", 4'b0000);

    // R9 sweep: every reachable flag pattern against every code
    for (int p = 0; p < 16; p++) begin
      logic n, z, c, v;
      {n, z, c, v} = p[3:0];
      if (n && z) continue;
      step("R9", 4'd14, 3'd0, 1'b1, 32'd0, 32'd0,
           z ? 32'h0 : (n ? 32'h80000000 : 32'h10), c, v);
      for (int cc = 0; cc < 16; cc++)
        step("R9", cc[3:0], 3'd6, 1'b0, 32'd0, 32'd0, 32'h0, 1'b0, 1'b0);
    end

    // R12 random stream of predicated instructions of every class
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 4 == 0) ? a : $urandom;
      if ($urandom % 8 == 0) b = 32'h80000000;
      step("R12", 4'($urandom), 3'($urandom), 1'($urandom), a, b,
           ($urandom % 5 == 0) ? 32'h0 : $urandom, 1'($urandom), 1'($urandom));
      if ($urandom % 16 == 0) idle();
    end
    expectFlags("R12", refFlags);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule